// File: doc/BRIEF.md
# Security Association Key Store

This block holds the cipher keys of a link-layer encryption engine, one per security association. Each entry is found by content: its tag is the 64-bit secure channel identifier joined with the 2-bit association number. A host port loads or replaces a key under a tag, or invalidates a tag. A separate lookup port is used by the datapath once per frame. It presents a tag and, one clock later, receives a hit flag and the stored key.

The host side has no read path at all. A key that has been written can leave the block only through the lookup port, toward the cipher. The number of entries (`ENTRIES`, default 256) and the key width (`KEY_W`, 128 by default, 256 as the alternative) are parameters. Tags sit in a register array that is compared in parallel. Keys sit in a simple dual-port memory with a synchronous read, so that block RAM can be inferred.

Top module: `sa_key_store`

## Requirements
- R1: With `lk_valid` high, a tag `{lk_sci, lk_an}` that equals a stored valid tag in all 66 bits gives `lk_hit`=1 and that entry's key on `lk_key` exactly one clock later. A tag that differs only in the association number does not match.
- R2: A lookup that matches no valid entry, or any cycle with `lk_valid` low, gives `lk_hit`=0 and an all-zero `lk_key` one clock later.
- R3: A write (`host_op`=2'b01) of a tag not yet stored, while a free entry exists, stores tag and key, and later lookups of that tag return the key.
- R4: A write of a tag already stored replaces that entry's key and does not allocate another entry. This also works when the store is full.
- R5: An invalidate (`host_op`=2'b10) removes the matching entry, so later lookups miss and the entry can be reused. Invalidating an absent tag changes nothing.
- R6: A write of a new tag when all `ENTRIES` entries are valid is rejected. The store stays unchanged and `host_err` is high for exactly the one cycle after that write.
- R7: Synchronous active-high `rst` clears every entry's valid flag and `host_err`.
- R8: `host_op` values 2'b00 and 2'b11 are no-ops and change no entry.
- R9: The host port has no key read path. Its only output is `host_err`, which stays low for accepted operations.
- R10: A lookup in the same cycle as a host operation on the same tag sees the contents from before that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_op | input | 2 | 00 idle, 01 write, 10 invalidate, 11 idle |
| host_sci | input | 64 | Secure channel identifier of host operation |
| host_an | input | 2 | Association number of host operation |
| host_key | input | KEY_W | Key to store on write |
| host_err | output | 1 | One-cycle pulse: write rejected, store full |
| lk_valid | input | 1 | Lookup request |
| lk_sci | input | 64 | Secure channel identifier to look up |
| lk_an | input | 2 | Association number to look up |
| lk_hit | output | 1 | Registered hit flag |
| lk_key | output | KEY_W | Key of the hit entry, zero on miss |

## Verification
A table of write, overwrite, invalidate, reserved-code and absent-tag steps is followed by a lookup after each step. This separates true allocation from overwrite, removal from a no-op, and a hit from a stale entry. The store is then filled to capacity. Three further steps follow: a rejected new tag, an overwrite while full, and reuse of an entry after invalidation. These tell the full check apart from the existing-tag check. Directed cases cover a tag that differs only in the association number, a lookup with the request low, a lookup and a write to the same tag in one cycle, and reset clearing.

// File: rtl/sa_key_pkg.sv
package sa_key_pkg;
  localparam int SCI_W = 64;
  localparam int AN_W  = 2;
  localparam int TAG_W = SCI_W + AN_W;

  typedef enum logic [1:0] {
    HOP_IDLE  = 2'b00,
    HOP_WRITE = 2'b01,
    HOP_INVAL = 2'b10,
    HOP_RSVD  = 2'b11
  } host_op_e;
endpackage

// File: rtl/sakey_prio_enc.sv
module sakey_prio_enc #(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
    any = |vec;
  end
endmodule

// File: rtl/sakey_tag_cam.sv
module sakey_tag_cam #(
  parameter int ENTRIES = 256,
  parameter int TAG_W   = 66,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TAG_W-1:0]   lk_tag,
  input  logic [TAG_W-1:0]   hs_tag,
  input  logic               set_en,
  input  logic [IDX_W-1:0]   set_idx,
  input  logic               clr_en,
  output logic [ENTRIES-1:0] lk_match,
  output logic [ENTRIES-1:0] hs_match,
  output logic [ENTRIES-1:0] valid
);
  logic [TAG_W-1:0] tags [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (set_en && set_idx == IDX_W'(e)) tags[e] <= hs_tag;
    end

    always_ff @(posedge clk) begin
      if (rst)                                  valid[e] <= 1'b0;
      else if (set_en && set_idx == IDX_W'(e))  valid[e] <= 1'b1;
      else if (clr_en && hs_match[e])           valid[e] <= 1'b0;
    end

    assign lk_match[e] = valid[e] && (tags[e] == lk_tag);
    assign hs_match[e] = valid[e] && (tags[e] == hs_tag);
  end

  // R4: tags stay unique, so a host tag matches at most one entry
  a_r4_unique_tag: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hs_match));
endmodule

// File: rtl/sakey_key_ram.sv
module sakey_key_ram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 128,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sa_key_store.sv
module sa_key_store
  import sa_key_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int KEY_W   = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       host_op,
  input  logic [63:0]      host_sci,
  input  logic [1:0]       host_an,
  input  logic [KEY_W-1:0] host_key,
  output logic             host_err,
  input  logic             lk_valid,
  input  logic [63:0]      lk_sci,
  input  logic [1:0]       lk_an,
  output logic             lk_hit,
  output logic [KEY_W-1:0] lk_key
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  host_op_e           op;
  logic [TAG_W-1:0]   hs_tag, lk_tag;
  logic [ENTRIES-1:0] lk_match, hs_match, valid;
  logic [IDX_W-1:0]   lk_idx, hs_idx, free_idx, wr_idx;
  logic               lk_any, hs_any, free_any, full;
  logic               do_write, do_inval;
  logic               hit_q;
  logic [KEY_W-1:0]   ram_q;

  assign op     = host_op_e'(host_op);
  assign hs_tag = {host_sci, host_an};
  assign lk_tag = {lk_sci, lk_an};

  sakey_tag_cam #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_cam (
    .clk      (clk),
    .rst      (rst),
    .lk_tag   (lk_tag),
    .hs_tag   (hs_tag),
    .set_en   (do_write),
    .set_idx  (wr_idx),
    .clr_en   (do_inval),
    .lk_match (lk_match),
    .hs_match (hs_match),
    .valid    (valid)
  );

  sakey_prio_enc #(.N(ENTRIES), .IDX_W(IDX_W)) u_enc_lk (
    .vec (lk_match), .idx (lk_idx), .any (lk_any)
  );

  sakey_prio_enc #(.N(ENTRIES), .IDX_W(IDX_W)) u_enc_hs (
    .vec (hs_match), .idx (hs_idx), .any (hs_any)
  );

  sakey_prio_enc #(.N(ENTRIES), .IDX_W(IDX_W)) u_enc_free (
    .vec (~valid), .idx (free_idx), .any (free_any)
  );

  assign full     = !free_any;
  assign wr_idx   = hs_any ? hs_idx : free_idx;
  assign do_write = (op == HOP_WRITE) && (hs_any || !full);
  assign do_inval = (op == HOP_INVAL) && hs_any;

  sakey_key_ram #(.DEPTH(ENTRIES), .WIDTH(KEY_W), .AW(IDX_W)) u_ram (
    .clk   (clk),
    .we    (do_write),
    .waddr (wr_idx),
    .wdata (host_key),
    .raddr (lk_idx),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q    <= 1'b0;
      host_err <= 1'b0;
    end else begin
      hit_q    <= lk_valid && lk_any;
      host_err <= (op == HOP_WRITE) && !hs_any && full;
    end
  end

  assign lk_hit = hit_q;
  assign lk_key = hit_q ? ram_q : '0;

  // R1: a lookup tag selects at most one entry
  a_r1_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));

  // R2: a miss returns no hit and a zero key on the next cycle
  a_r2_miss_zero: assert property (@(posedge clk) disable iff (rst)
    (!lk_valid || !lk_any) |=> (!lk_hit && lk_key == '0));

  // R3: a write of a new tag with room takes exactly one more entry
  a_r3_alloc: assert property (@(posedge clk) disable iff (rst)
    (op == HOP_WRITE && !hs_any && !full) |=>
      (!host_err && $countones(valid) == $countones($past(valid)) + 1));

  // R4: a write of a present tag keeps the entry count
  a_r4_overwrite: assert property (@(posedge clk) disable iff (rst)
    (op == HOP_WRITE && hs_any) |=>
      (!host_err && $countones(valid) == $countones($past(valid))));

  // R5: invalidating a present tag frees exactly one entry
  a_r5_inval: assert property (@(posedge clk) disable iff (rst)
    (op == HOP_INVAL && hs_any) |=>
      ($countones(valid) + 1 == $countones($past(valid))));

  // R6: a new tag on a full store is rejected and flagged
  a_r6_reject: assert property (@(posedge clk) disable iff (rst)
    (op == HOP_WRITE && !hs_any && full) |=>
      (host_err && valid == $past(valid)));

  // R8: idle codes leave every valid flag untouched
  a_r8_idle: assert property (@(posedge clk) disable iff (rst)
    (op == HOP_IDLE || op == HOP_RSVD) |=> (valid == $past(valid) && !host_err));
endmodule

// File: tb/sa_key_store_test.sv
module sa_key_store_test;
  localparam int N  = 8;
  localparam int KW = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    host_op = 2'b00;
  logic [63:0]   host_sci = '0;
  logic [1:0]    host_an = '0;
  logic [KW-1:0] host_key = '0;
  logic          host_err;
  logic          lk_valid = 1'b0;
  logic [63:0]   lk_sci = '0;
  logic [1:0]    lk_an = '0;
  logic          lk_hit;
  logic [KW-1:0] lk_key;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  sa_key_store #(.ENTRIES(N), .KEY_W(KW)) uut (
    .clk (clk), .rst (rst),
    .host_op (host_op), .host_sci (host_sci), .host_an (host_an),
    .host_key (host_key), .host_err (host_err),
    .lk_valid (lk_valid), .lk_sci (lk_sci), .lk_an (lk_an),
    .lk_hit (lk_hit), .lk_key (lk_key)
  );

  function automatic logic [63:0] sci_of(input logic [7:0] id);
    return {56'hF00D_5EC0_0000_00, id};
  endfunction

  function automatic logic [KW-1:0] key_of(input logic [7:0] id);
    return {4{24'h5A5A00, id}};
  endfunction

  task automatic chk(input string req, input logic [KW-1:0] act, input logic [KW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one host op, then one lookup; error and lookup results checked
  task automatic step(input string req, input logic [1:0] op, input logic [7:0] hid,
                      input logic [7:0] kid, input logic [7:0] lid,
                      input logic ehit, input logic [7:0] ekid, input logic eerr);
    @(negedge clk);
    host_op = op; host_sci = sci_of(hid); host_an = hid[1:0]; host_key = key_of(kid);
    lk_valid = 1'b0;
    @(negedge clk);
    chk({req, " err"}, KW'(host_err), KW'(eerr));
    host_op = 2'b00;
    lk_valid = 1'b1; lk_sci = sci_of(lid); lk_an = lid[1:0];
    @(negedge clk);
    chk({req, " hit"}, KW'(lk_hit), KW'(ehit));
    chk({req, " key"}, lk_key, ehit ? key_of(ekid) : '0);
    lk_valid = 1'b0;
  endtask

  task automatic look(input string req, input logic [7:0] lid, input logic ehit,
                      input logic [7:0] ekid);
    @(negedge clk);
    lk_valid = 1'b1; lk_sci = sci_of(lid); lk_an = lid[1:0];
    @(negedge clk);
    chk({req, " hit"}, KW'(lk_hit), KW'(ehit));
    chk({req, " key"}, lk_key, ehit ? key_of(ekid) : '0);
    lk_valid = 1'b0;
  endtask

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] hid;
    logic [7:0] kid;
    logic [7:0] lid;
    logic       ehit;
    logic [7:0] ekid;
    logic       eerr;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'b01, 8'd1, 8'd1, 8'd1, 1'b1, 8'd1, 1'b0},  // R3 allocate
    '{2'b01, 8'd2, 8'd2, 8'd2, 1'b1, 8'd2, 1'b0},  // R3 second entry
    '{2'b00, 8'd3, 8'd3, 8'd3, 1'b0, 8'd0, 1'b0},  // R2 absent tag
    '{2'b01, 8'd1, 8'd5, 8'd1, 1'b1, 8'd5, 1'b0},  // R4 overwrite
    '{2'b10, 8'd2, 8'd0, 8'd2, 1'b0, 8'd0, 1'b0},  // R5 invalidate
    '{2'b10, 8'd3, 8'd0, 8'd1, 1'b1, 8'd5, 1'b0},  // R5 absent invalidate
    '{2'b11, 8'd4, 8'd4, 8'd4, 1'b0, 8'd0, 1'b0},  // R8 reserved code
    '{2'b01, 8'd2, 8'd6, 8'd2, 1'b1, 8'd6, 1'b0}   // R3 reuse after R5
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R7: empty after reset, no error flag
    chk("R7 err after reset", KW'(host_err), '0);
    look("R7 lookup after reset", 8'd1, 1'b0, 8'd0);

    for (int v = 0; v < 8; v++)
      step($sformatf("R1 vector %0d", v), VECS[v].op, VECS[v].hid, VECS[v].kid,
           VECS[v].lid, VECS[v].ehit, VECS[v].ekid, VECS[v].eerr);

    // R1: same channel id, other association number
    @(negedge clk);
    lk_valid = 1'b1; lk_sci = sci_of(8'd1); lk_an = 2'b10;
    @(negedge clk);
    chk("R1 other AN hit", KW'(lk_hit), '0);
    chk("R1 other AN key", lk_key, '0);
    lk_valid = 1'b0;

    // R2: request low while the tag is present
    @(negedge clk);
    lk_valid = 1'b0; lk_sci = sci_of(8'd1); lk_an = 2'b01;
    @(negedge clk);
    chk("R2 idle hit", KW'(lk_hit), '0);
    chk("R2 idle key", lk_key, '0);

    // R10: same-cycle write and lookup of tag 1 sees key 5
    @(negedge clk);
    host_op = 2'b01; host_sci = sci_of(8'd1); host_an = 2'b01; host_key = key_of(8'd7);
    lk_valid = 1'b1; lk_sci = sci_of(8'd1); lk_an = 2'b01;
    @(negedge clk);
    host_op = 2'b00;
    chk("R10 old key", lk_key, key_of(8'd5));
    chk("R9 no err on accepted write", KW'(host_err), '0);
    @(negedge clk);
    chk("R10 new key next cycle", lk_key, key_of(8'd7));
    lk_valid = 1'b0;

    // R7: reset removes every entry
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    look("R7 cleared tag 1", 8'd1, 1'b0, 8'd0);
    look("R7 cleared tag 2", 8'd2, 1'b0, 8'd0);

    // R6: fill the store, then a new tag is rejected
    for (int i = 0; i < N; i++)
      step("R3 fill", 2'b01, 8'(16 + i), 8'(16 + i), 8'(16 + i), 1'b1, 8'(16 + i), 1'b0);
    step("R6 reject when full", 2'b01, 8'd40, 8'd40, 8'd40, 1'b0, 8'd0, 1'b1);
    @(negedge clk);
    chk("R6 err one cycle only", KW'(host_err), '0);
    for (int i = 0; i < N; i++)
      look("R6 store unchanged", 8'(16 + i), 1'b1, 8'(16 + i));
    step("R4 overwrite while full", 2'b01, 8'd19, 8'd99, 8'd19, 1'b1, 8'd99, 1'b0);
    step("R5 free one entry", 2'b10, 8'd21, 8'd0, 8'd21, 1'b0, 8'd0, 1'b0);
    step("R3 reuse freed entry", 2'b01, 8'd40, 8'd40, 8'd40, 1'b1, 8'd40, 1'b0);
    look("R4 entry 19 kept", 8'd19, 1'b1, 8'd99);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule